// File: doc/BRIEF.md
# Dual-Port 8-Bit GPIO Register Bank

This block holds the register file behind a 16-pin general-purpose port, organised as two 8-bit ports. A bus front end (serial or parallel, not part of this block) issues single-byte writes and read requests against an 8-entry byte map. The bank drives a value and an output enable for every pin, and samples the pin levels through a two-flop synchroniser.

The map is grouped in pairs: an even address selects the low port (pins 7..0) and an odd address the high port (pins 15..8). Addresses 0/1 are the input capture, 2/3 the output data, 4/5 the polarity masks and 6/7 the direction controls. An input read latches the synchronised pin levels into the capture register in that cycle. The read data is that capture XORed with the polarity mask. A one-cycle pulse for the port that was read goes to downstream interrupt logic, together with the raw captured levels.

Top module: `gpio16_regbank`

## Requirements
- R1: After reset the output data is 0xFF on both ports, the polarity masks are 0x00, and the direction bytes are 0xFF. So pin_out is 16'hFFFF and pin_oe is 0. The capture register is 0, and rd_valid and in_rd are low.
- R2: A write with wr_en high updates the addressed byte at the next clock edge. wr_addr[2:1] selects the group: 1 for output data, 2 for polarity, 3 for direction. wr_addr[0] selects the port: 0 for pins 7..0, 1 for pins 15..8. The other byte of the pair is unchanged.
- R3: A write to address 0 or 1 changes no register: pin_out, pin_oe, the capture register and every later read are as if the write had not happened.
- R4: A read request on rd_en is answered one cycle later, with rd_valid high for exactly that cycle. A read of an output data, polarity or direction byte returns the stored byte, whatever level the pins have.
- R5: A read of address 0 or 1 returns the pin levels seen two clock edges before the request, XORed with the port's polarity mask. A mask bit of 1 inverts that bit.
- R6: An input read captures the levels of all eight pins of that port, whether each pin is an input or an output. Without an input read of that port, the port's half of in_cap does not change.
- R7: pin_oe[i] is high exactly when direction bit i is 0, and pin_out[i] equals output data bit i.
- R8: An input read of port p raises in_rd[p] for one cycle, in the same cycle as rd_valid. At most one bit of in_rd is high, and in_cap holds the raw capture, without polarity applied.
- R9: When a read and a write fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address (group in [2:1], port in [0]) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read answer strobe, one cycle after rd_en |
| in_rd | output | 2 | Per-port input-read pulse |
| in_cap | output | 16 | Raw captured input levels |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Drive value per pin |
| pin_oe | output | 16 | Output enable per pin |

## Verification
Every cycle, the assertions check these relations:
- rd_valid only follows a request.
- The input-read pulse is one-hot and coincides with rd_valid.
- A write to the input addresses leaves the pins untouched.
- The capture register holds when no input read occurs.
- A read-back of the low direction and output bytes agrees with pin_oe and pin_out.

Only the bench's scenarios can show several behaviours:
- The two-edge synchroniser latency.
- Polarity inversion of real pin patterns.
- Capture of pins that are driven as outputs.
- Read-before-write ordering in a shared cycle.

These are covered by a cycle-accurate reference model compared on every clock.

// File: rtl/gpio16_regbank.sv
module gpio16_regbank #(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [PW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [2:0]      rd_addr,
  output logic [PW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [1:0]      in_rd,
  output logic [2*PW-1:0] in_cap,
  input  logic [2*PW-1:0] pin_in,
  output logic [2*PW-1:0] pin_out,
  output logic [2*PW-1:0] pin_oe
);
  localparam int NW = 2 * PW;
  localparam logic [1:0] G_IN  = 2'd0;
  localparam logic [1:0] G_OUT = 2'd1;
  localparam logic [1:0] G_POL = 2'd2;
  localparam logic [1:0] G_CFG = 2'd3;

  logic [NW-1:0] sync1, sync2, outr, polr, cfgr;
  logic [PW-1:0] rd_mux, sel_in, sel_out, sel_pol, sel_cfg;
  logic          rd_input;

  assign pin_out  = outr;
  assign pin_oe   = ~cfgr;
  assign rd_input = rd_en && (rd_addr[2:1] == G_IN);

  assign sel_in  = rd_addr[0] ? sync2[NW-1:PW] : sync2[PW-1:0];
  assign sel_out = rd_addr[0] ? outr[NW-1:PW]  : outr[PW-1:0];
  assign sel_pol = rd_addr[0] ? polr[NW-1:PW]  : polr[PW-1:0];
  assign sel_cfg = rd_addr[0] ? cfgr[NW-1:PW]  : cfgr[PW-1:0];

  always_comb begin
    case (rd_addr[2:1])
      G_IN:    rd_mux = sel_in ^ sel_pol;
      G_OUT:   rd_mux = sel_out;
      G_POL:   rd_mux = sel_pol;
      default: rd_mux = sel_cfg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outr <= '1;
      polr <= '0;
      cfgr <= '1;
    end else if (wr_en) begin
      case (wr_addr[2:1])
        G_OUT: if (wr_addr[0]) outr[NW-1:PW] <= wr_data; else outr[PW-1:0] <= wr_data;
        G_POL: if (wr_addr[0]) polr[NW-1:PW] <= wr_data; else polr[PW-1:0] <= wr_data;
        G_CFG: if (wr_addr[0]) cfgr[NW-1:PW] <= wr_data; else cfgr[PW-1:0] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      in_rd    <= '0;
      in_cap   <= '0;
    end else begin
      rd_valid <= rd_en;
      in_rd    <= rd_input ? {rd_addr[0], ~rd_addr[0]} : 2'b00;
      if (rd_en) rd_data <= rd_mux;
      if (rd_input) begin
        if (rd_addr[0]) in_cap[NW-1:PW] <= sync2[NW-1:PW];
        else            in_cap[PW-1:0]  <= sync2[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/gpio16_regbank_chk.sv
module gpio16_regbank_chk #(
  parameter int PW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_addr,
  input logic            rd_en,
  input logic [2:0]      rd_addr,
  input logic [PW-1:0]   rd_data,
  input logic            rd_valid,
  input logic [1:0]      in_rd,
  input logic [2*PW-1:0] in_cap,
  input logic [2*PW-1:0] pin_out,
  input logic [2*PW-1:0] pin_oe
);
  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R4

  AST_OUT_READ_MATCHES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_addr) == 3'd2 && !$past(wr_en && wr_addr == 3'd2))
      |-> rd_data == pin_out[PW-1:0]); // R4

  AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2:1] == 2'd0) |=> ($stable(pin_out) && $stable(pin_oe))); // R3

  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr[2:1] == 2'd0) |=> $stable(in_cap)); // R6

  AST_CFG_READ_MATCHES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_addr) == 3'd6 && !$past(wr_en && wr_addr == 3'd6))
      |-> rd_data == ~pin_oe[PW-1:0]); // R7

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_rd)); // R8

  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd != 2'b00) |-> rd_valid); // R8
endmodule

bind gpio16_regbank gpio16_regbank_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
  .in_rd(in_rd), .in_cap(in_cap), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio16_regbank_bench.sv
`timescale 1ns/1ps
module gpio16_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] pin_in = '0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [1:0]  in_rd;
  logic [15:0] in_cap, pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio16_regbank u_gpio16_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .in_rd(in_rd), .in_cap(in_cap), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: register state as plain arrays, read before write
  logic [7:0]  m_out[2], m_pol[2], m_cfg[2], m_cap[2];
  logic [15:0] m_hist[$];
  logic [7:0]  m_data;
  logic        m_valid;
  logic [1:0]  m_inrd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_out[p] = 8'hFF; m_pol[p] = 8'h00; m_cfg[p] = 8'hFF; m_cap[p] = 8'h00;
      end
      m_hist = {16'h0000, 16'h0000};
      m_valid = 1'b0; m_inrd = 2'b00; m_data = 8'h00;
    end else begin
      logic [15:0] seen;
      int p;
      seen = m_hist[0];
      p = int'(rd_addr[0]);
      m_valid = rd_en;
      m_inrd = 2'b00;
      if (rd_en) begin
        if (rd_addr < 3'd2) begin
          m_cap[p] = p ? seen[15:8] : seen[7:0];
          m_data = m_cap[p] ^ m_pol[p];
          m_inrd[p] = 1'b1;
        end else if (rd_addr < 3'd4) m_data = m_out[p];
        else if (rd_addr < 3'd6)     m_data = m_pol[p];
        else                         m_data = m_cfg[p];
      end
      if (wr_en) begin
        p = int'(wr_addr[0]);
        if (wr_addr >= 3'd6)      m_cfg[p] = wr_data;
        else if (wr_addr >= 3'd4) m_pol[p] = wr_data;
        else if (wr_addr >= 3'd2) m_out[p] = wr_data;
      end
      void'(m_hist.pop_front());
      m_hist.push_back(pin_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_out == {m_out[1], m_out[0]}, "R2 pin_out", pin_out, {m_out[1], m_out[0]});
      chk(pin_oe == ~{m_cfg[1], m_cfg[0]}, "R7 pin_oe", pin_oe, ~{m_cfg[1], m_cfg[0]});
      chk(rd_valid == m_valid, "R4 rd_valid", {15'd0, rd_valid}, {15'd0, m_valid});
      if (m_valid) chk(rd_data == m_data, "R5 rd_data", {8'd0, rd_data}, {8'd0, m_data});
      chk(in_rd == m_inrd, "R8 in_rd", {14'd0, in_rd}, {14'd0, m_inrd});
      chk(in_cap == {m_cap[1], m_cap[0]}, "R6 in_cap", in_cap, {m_cap[1], m_cap[0]});
    end
  end

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #2 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2 wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #2 rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #2 rd_en = 1'b0;
    @(negedge clk); d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(pin_out == 16'hFFFF, "R1 out default", pin_out, 16'hFFFF);
    chk(pin_oe == 16'h0000, "R1 oe default", pin_oe, 16'h0000);
    chk(in_cap == 16'h0000 && !rd_valid && in_rd == 2'b00, "R1 status", in_cap, 16'h0000);
    do_rd(3'd4, d); chk(d == 8'h00, "R1 pol default", {8'd0, d}, 16'h0000);
    do_rd(3'd7, d); chk(d == 8'hFF, "R1 cfg default", {8'd0, d}, 16'h00FF);

    // R2 / R7: drive low port outputs
    do_wr(3'd2, 8'hA5);
    do_wr(3'd6, 8'h0F);
    @(negedge clk);
    chk(pin_out == 16'hFFA5, "R2 out low", pin_out, 16'hFFA5);
    chk(pin_oe == 16'h00F0, "R7 oe low", pin_oe, 16'h00F0);
    do_wr(3'd3, 8'h3C);
    @(negedge clk);
    chk(pin_out == 16'h3CA5, "R2 out high", pin_out, 16'h3CA5);

    // R3: writes to the input addresses are dropped
    do_wr(3'd0, 8'h00);
    do_wr(3'd1, 8'h5A);
    @(negedge clk);
    chk(pin_out == 16'h3CA5 && pin_oe == 16'h00F0, "R3 pins", pin_out, 16'h3CA5);
    do_rd(3'd6, d); chk(d == 8'h0F, "R3 cfg kept", {8'd0, d}, 16'h000F);
    do_rd(3'd5, d); chk(d == 8'h00, "R3 pol kept", {8'd0, d}, 16'h0000);

    // R5: input reads with and without inversion
    pin_in = 16'h1234; settle();
    do_rd(3'd0, d); chk(d == 8'h34, "R5 in low", {8'd0, d}, 16'h0034);
    do_rd(3'd1, d); chk(d == 8'h12, "R5 in high", {8'd0, d}, 16'h0012);
    chk(in_cap == 16'h1234, "R8 raw cap", in_cap, 16'h1234);
    do_wr(3'd5, 8'hFF);
    do_rd(3'd1, d); chk(d == 8'hED, "R5 inverted", {8'd0, d}, 16'h00ED);
    chk(in_cap == 16'h1234, "R8 cap no pol", in_cap, 16'h1234);

    // R6: pins configured as outputs still captured
    do_wr(3'd6, 8'h00);
    pin_in = 16'h12C3; settle();
    do_rd(3'd0, d); chk(d == 8'hC3, "R6 out pins read", {8'd0, d}, 16'h00C3);

    // R4: output read returns the flop, not the pin
    do_rd(3'd2, d); chk(d == 8'hA5, "R4 flop not pin", {8'd0, d}, 16'h00A5);

    // R5 boundary: pin change one cycle before read not yet seen
    @(posedge clk); #2 pin_in = 16'h12FF; rd_en = 1'b1; rd_addr = 3'd0;
    @(posedge clk); #2 rd_en = 1'b0;
    @(negedge clk); chk(rd_data == 8'hC3, "R5 sync latency", {8'd0, rd_data}, 16'h00C3);

    // R9: read and write in the same cycle
    @(posedge clk); #2 rd_en = 1'b1; rd_addr = 3'd3; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h77;
    @(posedge clk); #2 rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk); chk(rd_data == 8'h3C, "R9 read old", {8'd0, rd_data}, 16'h003C);
    chk(pin_out[15:8] == 8'h77, "R9 write lands", {8'd0, pin_out[15:8]}, 16'h0077);

    // R8: back-to-back alternating port reads
    @(posedge clk); #2 rd_en = 1'b1; rd_addr = 3'd0;
    @(posedge clk); #2 rd_addr = 3'd1;
    @(negedge clk); chk(in_rd == 2'b01, "R8 pulse p0", {14'd0, in_rd}, 16'h0001);
    @(posedge clk); #2 rd_en = 1'b0;
    @(negedge clk); chk(in_rd == 2'b10, "R8 pulse p1", {14'd0, in_rd}, 16'h0002);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2
      wr_en = 1'($urandom); wr_addr = 3'($urandom); wr_data = 8'($urandom);
      rd_en = 1'($urandom); rd_addr = 3'($urandom);
      if ((i % 3) == 0) pin_in = 16'($urandom);
    end
    @(posedge clk); #2 wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule